// File: doc/BRIEF.md
# Next-PC Fetch Unit

This block holds the program counter of a single-cycle 32-bit processor and works out the address of the following instruction. In every cycle it presents the current PC as the fetch address. Alongside that it forms three candidates: the sequential address, a branch target and a jump target. It loads one of them on the next rising clock edge.

Two plain control pins make the choice. The branch-taken pin is driven by the surrounding control logic, which ANDs the branch decode with the ALU zero flag. The jump pin is driven by the jump decode. The current instruction supplies the 16-bit branch offset field and the 26-bit jump field. Instruction memory, decoding and exceptions are outside this block. There is no valid/ready handshake, because the PC advances on every cycle by definition.

Top module: `npc_fetch_unit`

## Requirements
- R1: While the synchronous reset pin is high at a rising edge, the PC is loaded with 0x00000000. Reset wins over the jump and branch-taken pins.
- R2: With neither jump nor branch-taken high, the PC becomes PC + 4 at the next rising edge.
- R3: With branch-taken high and jump low, the PC becomes PC + 4 + (offset field sign-extended to 32 bits and shifted left by 2) at the next rising edge.
- R4: An offset field with bit 15 set moves the PC backwards. For example, 0xFFFE gives PC + 4 − 8 and 0x8000 gives PC + 4 − 0x20000.
- R5: While branch-taken is low, the offset field has no effect on the next PC.
- R6: With jump high, the next PC is bits 31..28 of PC + 4, then the 26-bit jump field, then two zero bits. The upper four bits come from PC + 4 even when PC + 4 has crossed into a new 256 MiB region.
- R7: When jump and branch-taken are both high, the jump target is taken.
- R8: Bits 1..0 of the fetch address are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the PC updates on the rising edge |
| srst_i | input | 1 | Synchronous reset, active high |
| br_taken_i | input | 1 | Branch condition met (branch decode AND ALU zero) |
| jmp_i | input | 1 | Current instruction is an unconditional jump |
| imm16_i | input | 16 | Signed word offset from the current instruction |
| jfld26_i | input | 26 | Jump word-index field from the current instruction |
| fetch_addr_o | output | 32 | Current PC, used as the instruction fetch address |

## Verification
Every result of this block is due exactly one rising edge after its inputs are applied, because the PC register is the only storage on the path. The offset and jump fields feed it through purely combinational logic. The bench therefore changes inputs on a falling edge and reads the fetch address on the following falling edge, half a cycle after the update. The checker compares the new PC against the candidate computed from the previous cycle's PC and inputs.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned NPC_ADDR_W = 32;
  localparam int unsigned NPC_IMM_W  = 16;
  localparam int unsigned NPC_JFLD_W = 26;

  // Source of the next PC, in increasing priority order.
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2
  } nxt_src_e;

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int unsigned ADDR_W     = npc_pkg::NPC_ADDR_W,
  parameter int unsigned IMM_W      = npc_pkg::NPC_IMM_W,
  parameter int unsigned JFLD_W     = npc_pkg::NPC_JFLD_W,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JFLD_W-1:0] jfld_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] br_o,
  output logic [ADDR_W-1:0] jmp_o
);

  localparam int unsigned INSTR_BYTES = 1 << ALIGN_BITS;
  localparam int unsigned SEXT_W      = ADDR_W - IMM_W - ALIGN_BITS;
  localparam int unsigned REGION_W    = ADDR_W - JFLD_W - ALIGN_BITS;

  logic [ADDR_W-1:0] offs_bytes;

  // Sequential address: instructions are a fixed number of bytes long.
  assign seq_o = pc_i + ADDR_W'(INSTR_BYTES);

  // Word offset, sign-extended and scaled to bytes.
  assign offs_bytes = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_BITS{1'b0}}};
  assign br_o       = seq_o + offs_bytes;

  // Region bits of the sequential address, with the word index below them.
  assign jmp_o = {seq_o[ADDR_W-1 -: REGION_W], jfld_i, {ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int unsigned ADDR_W = npc_pkg::NPC_ADDR_W
) (
  input  logic              br_taken_i,
  input  logic              jmp_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] br_i,
  input  logic [ADDR_W-1:0] jmp_tgt_i,
  output logic [ADDR_W-1:0] nxt_o
);

  npc_pkg::nxt_src_e src;

  // Jump outranks a taken branch; otherwise fall through.
  always_comb begin
    if (jmp_i)           src = npc_pkg::NXT_JUMP;
    else if (br_taken_i) src = npc_pkg::NXT_BRANCH;
    else                 src = npc_pkg::NXT_SEQ;
  end

  always_comb begin
    unique case (src)
      npc_pkg::NXT_JUMP:   nxt_o = jmp_tgt_i;
      npc_pkg::NXT_BRANCH: nxt_o = br_i;
      default:             nxt_o = seq_i;
    endcase
  end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned ADDR_W     = npc_pkg::NPC_ADDR_W,
  parameter int unsigned ALIGN_BITS = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              srst_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam int unsigned STORE_W = ADDR_W - ALIGN_BITS;

  logic [STORE_W-1:0] pc_q;

  // Only the word-index bits are stored; the low bits are tied off.
  always_ff @(posedge clk_i) begin
    if (srst_i) pc_q <= RESET_ADDR[ADDR_W-1:ALIGN_BITS];
    else        pc_q <= nxt_i[ADDR_W-1:ALIGN_BITS];
  end

  generate
    if (ALIGN_BITS > 0) begin : g_aligned
      logic unused_low;
      assign unused_low = ^nxt_i[ALIGN_BITS-1:0];
      assign pc_o = {pc_q, {ALIGN_BITS{1'b0}}};
    end else begin : g_byte
      assign pc_o = pc_q;
    end
  endgenerate

endmodule

// File: rtl/npc_fetch_unit.sv
module npc_fetch_unit #(
  parameter int unsigned ADDR_W = npc_pkg::NPC_ADDR_W,
  parameter int unsigned IMM_W  = npc_pkg::NPC_IMM_W,
  parameter int unsigned JFLD_W = npc_pkg::NPC_JFLD_W,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              srst_i,
  input  logic              br_taken_i,
  input  logic              jmp_i,
  input  logic [IMM_W-1:0]  imm16_i,
  input  logic [JFLD_W-1:0] jfld26_i,
  output logic [ADDR_W-1:0] fetch_addr_o
);

  localparam int unsigned ALIGN_BITS = 2;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;
  logic [ADDR_W-1:0] nxt_addr;

  npc_target_gen #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .JFLD_W(JFLD_W), .ALIGN_BITS(ALIGN_BITS)
  ) tgt_i (
    .pc_i(pc), .imm_i(imm16_i), .jfld_i(jfld26_i),
    .seq_o(seq_addr), .br_o(br_addr), .jmp_o(jmp_addr)
  );

  npc_select #(.ADDR_W(ADDR_W)) sel_i (
    .br_taken_i(br_taken_i), .jmp_i(jmp_i),
    .seq_i(seq_addr), .br_i(br_addr), .jmp_tgt_i(jmp_addr),
    .nxt_o(nxt_addr)
  );

  npc_pc_reg #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .RESET_ADDR(RESET_ADDR)
  ) pcr_i (
    .clk_i(clk_i), .srst_i(srst_i), .nxt_i(nxt_addr), .pc_o(pc)
  );

  assign fetch_addr_o = pc;

endmodule

// File: rtl/npc_fetch_unit_chk.sv
module npc_fetch_unit_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JFLD_W = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input logic              clk_i,
  input logic              srst_i,
  input logic              br_taken_i,
  input logic              jmp_i,
  input logic [IMM_W-1:0]  imm16_i,
  input logic [JFLD_W-1:0] jfld26_i,
  input logic [ADDR_W-1:0] fetch_addr_o
);

  localparam int unsigned SEXT_W   = ADDR_W - IMM_W - 2;
  localparam int unsigned REGION_W = ADDR_W - JFLD_W - 2;

  logic [ADDR_W-1:0] exp_seq, exp_br, exp_jmp;
  assign exp_seq = fetch_addr_o + ADDR_W'(4);
  assign exp_br  = exp_seq + {{SEXT_W{imm16_i[IMM_W-1]}}, imm16_i, 2'b00};
  assign exp_jmp = {exp_seq[ADDR_W-1 -: REGION_W], jfld26_i, 2'b00};

  // R1: first cycle out of reset shows the reset address
  a_r1_reset_addr: assert property (@(posedge clk_i) disable iff (srst_i)
    $past(srst_i) |-> fetch_addr_o == RESET_ADDR);

  // R2: plain step
  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (srst_i)
    (!jmp_i && !br_taken_i) |=> fetch_addr_o == $past(exp_seq));

  // R3, R4: taken branch, either direction
  a_r3_branch_target: assert property (@(posedge clk_i) disable iff (srst_i)
    (!jmp_i && br_taken_i) |=> fetch_addr_o == $past(exp_br));

  // R6, R7: jump, regardless of branch-taken
  a_r6_jump_target: assert property (@(posedge clk_i) disable iff (srst_i)
    jmp_i |=> fetch_addr_o == $past(exp_jmp));

endmodule

bind npc_fetch_unit npc_fetch_unit_chk #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .JFLD_W(JFLD_W), .RESET_ADDR(RESET_ADDR)
) chk_i (
  .clk_i(clk_i), .srst_i(srst_i), .br_taken_i(br_taken_i), .jmp_i(jmp_i),
  .imm16_i(imm16_i), .jfld26_i(jfld26_i), .fetch_addr_o(fetch_addr_o)
);

// File: tb/npc_fetch_unit_tb_top.sv
module npc_fetch_unit_tb_top;

  logic        clk = 1'b0;
  logic        srst_i = 1'b1;
  logic        br_taken_i = 1'b0;
  logic        jmp_i = 1'b0;
  logic [15:0] imm16_i = '0;
  logic [25:0] jfld26_i = '0;
  logic [31:0] fetch_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  npc_fetch_unit dut_i (
    .clk_i(clk), .srst_i(srst_i), .br_taken_i(br_taken_i), .jmp_i(jmp_i),
    .imm16_i(imm16_i), .jfld26_i(jfld26_i), .fetch_addr_o(fetch_addr_o)
  );

  // {br_taken, jmp, imm16, jfld26, expected next PC}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0000_0004}, // R2 step
    {1'b0, 1'b0, 16'h1234, 26'h0000000, 32'h0000_0008}, // R2, R5 offset ignored
    {1'b1, 1'b0, 16'h0003, 26'h0000000, 32'h0000_0018}, // R3 forward branch
    {1'b1, 1'b0, 16'hFFFE, 26'h0000000, 32'h0000_0014}, // R4 backward branch
    {1'b0, 1'b0, 16'h7FFF, 26'h0000000, 32'h0000_0018}, // R5 not taken
    {1'b0, 1'b1, 16'h0000, 26'h0000040, 32'h0000_0100}, // R6 jump
    {1'b1, 1'b1, 16'h0005, 26'h0000080, 32'h0000_0200}, // R7 jump beats branch
    {1'b0, 1'b1, 16'h0000, 26'h3FFFFFF, 32'h0FFF_FFFC}, // R6 top of region
    {1'b0, 1'b1, 16'h0000, 26'h0000005, 32'h1000_0014}, // R6 region from PC+4
    {1'b1, 1'b0, 16'h8000, 26'h0000000, 32'h0FFE_0018}, // R4 largest backward
    {1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0FFE_001C}, // R2 step
    {1'b0, 1'b1, 16'h0000, 26'h0000001, 32'h0000_0004}  // R6 upper bits kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: fetch_addr actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    srst_i = 1'b0;
    check("R1", fetch_addr_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      br_taken_i = VEC[i][75];
      jmp_i      = VEC[i][74];
      imm16_i    = VEC[i][73:58];
      jfld26_i   = VEC[i][57:32];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", (VEC[i][74] ? 6 : (VEC[i][75] ? 3 : 2)), i),
            fetch_addr_o, VEC[i][31:0]);
      check("R8", {30'h0, fetch_addr_o[1:0]}, 32'h0);
    end

    // R1: reset outranks a pending jump
    srst_i = 1'b1; jmp_i = 1'b1; jfld26_i = 26'h0000100;
    @(posedge clk); @(negedge clk);
    check("R1 over jump", fetch_addr_o, 32'h0);
    srst_i = 1'b0; jmp_i = 1'b0;

    // R5: many offsets with branch low give plain steps
    for (int k = 0; k < 4; k++) begin
      imm16_i = 16'h8000 >> k;
      @(posedge clk); @(negedge clk);
      check("R5", fetch_addr_o, 32'(4 * (k + 1)));
    end

    // R3 zero offset lands on PC+4
    br_taken_i = 1'b1; imm16_i = 16'h0000;
    @(posedge clk); @(negedge clk);
    check("R3 zero offset", fetch_addr_o, 32'h14);

    // R4 offset -1 word loops on itself
    imm16_i = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    check("R4 self loop", fetch_addr_o, 32'h14);
    br_taken_i = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule